// File: doc/BRIEF.md
# Fixed-Pattern Output Responder FIFO

This block is the egress buffer of a trusted unit that must not reveal, through the timing of its outputs, how much result data it holds. An internal producer fills a word buffer. The buffer is drained only when the outside world asks for output. Each request names a word count. The block answers every request with the same timing: a constant start latency, then a fixed number of cycles between words, whatever the buffer holds.

Each answer slot carries the oldest buffered word if one is present. Otherwise it carries a constant filler word. A tag marks every emitted word as real or filler, so that a later cipher stage can make the two look alike. The producer side never loses data. When the buffer is full, a full flag tells the writer to hold.

Requests that arrive while an answer is in progress wait in a small request queue and are served in order. The buffer level and an empty flag are exported so that a scheduler can decide when to run the producer.

Top module: `fixed_pattern_responder`

## Requirements
- R1: After reset, out_valid is 0, empty is 1, occupancy is 0 and wr_full is 0. No word is ever emitted without a request, even when the buffer holds data.
- R2: A request with req_size = Z (1 to 2^ZW-1) produces exactly Z cycles with out_valid high.
- R3: The request is sampled at rising edge k. If no earlier answer is pending, the first word of the answer is presented after edge k+1+DELAY. Each later word of the same answer follows RATE cycles after the one before it. out_valid is high for one cycle per word.
- R4: While the buffer is non-empty at a word slot, the slot carries the oldest buffered word with out_real = 1, and that word leaves the buffer.
- R5: If the buffer is empty at a word slot, the slot carries DUMMY_WORD with out_real = 0. One answer may mix real and filler words.
- R6: wr_full is 1 exactly when occupancy equals DEPTH. A write attempted while wr_full is 1 is not stored and does not change the buffer contents.
- R7: occupancy equals the number of buffered words, and empty is 1 exactly when occupancy is 0.
- R8: A request that arrives during an answer is queued. Its countdown starts one cycle after the previous answer's last word: its first word appears DELAY+1 cycles after that last word.
- R9: A request with req_size = 0 is ignored. A request arriving when RQ_DEPTH requests are already waiting is discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Producer write strobe |
| wr_data | input | DW | Producer write word |
| wr_full | output | 1 | Buffer full; producer must hold |
| occupancy | output | $clog2(DEPTH+1) | Number of buffered words |
| empty | output | 1 | Buffer holds no word |
| req_valid | input | 1 | Output request strobe |
| req_size | input | ZW | Requested word count |
| out_valid | output | 1 | Output word present this cycle |
| out_data | output | DW | Output word (real or filler) |
| out_real | output | 1 | 1 for buffered data, 0 for filler |

## Verification
A request sampled at edge k has its first word registered at edge k+1+DELAY, and each later word lands exactly RATE edges after the previous one. The queued request that follows an answer lands DELAY+1 edges after that answer's last word. Writes and the buffer level respond one edge after the write strobe is sampled.

The bench drives inputs and samples outputs on falling edges while counting rising edges. A monitor records every output word with the edge count at which it appeared. Each scenario compares that record against edge numbers computed from DELAY and RATE, and it also checks the word values, the real/filler tags and the total number of words.

// File: rtl/resp_pkg.sv
package resp_pkg;
  typedef enum logic {
    SQ_IDLE = 1'b0,
    SQ_RUN  = 1'b1
  } sq_state_e;

  function automatic int unsigned max_of(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/resp_sync_fifo.sv
module resp_sync_fifo #(
  parameter int unsigned W     = 16,
  parameter int unsigned DEPTH = 4
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             push,
  input  logic [W-1:0]                     din,
  input  logic                             pop,
  output logic [W-1:0]                     dout,
  output logic                             full,
  output logic                             empty,
  output logic [$clog2(DEPTH+1)-1:0]       count
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [AW-1:0] wr_ptr, wr_ptr_nx, rd_ptr, rd_ptr_nx;
  logic [CW-1:0] cnt, cnt_nx;
  logic          do_push, do_pop;
  logic [W-1:0]  slot_rd [DEPTH];

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign full    = (cnt == CW'(DEPTH));
  assign empty   = (cnt == '0);
  assign count   = cnt;
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = slot_rd[rd_ptr];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic [W-1:0] slot_q;
    logic         slot_we;
    assign slot_we = do_push && (wr_ptr == AW'(i));
    always_ff @(posedge clk) begin
      if (slot_we) slot_q <= din;
    end
    assign slot_rd[i] = slot_q;
  end

  always_comb begin
    wr_ptr_nx = wr_ptr;
    rd_ptr_nx = rd_ptr;
    cnt_nx    = cnt;
    if (do_push) wr_ptr_nx = bump(wr_ptr);
    if (do_pop)  rd_ptr_nx = bump(rd_ptr);
    if (do_push && !do_pop)      cnt_nx = cnt + CW'(1);
    else if (!do_push && do_pop) cnt_nx = cnt - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      wr_ptr <= wr_ptr_nx;
      rd_ptr <= rd_ptr_nx;
      cnt    <= cnt_nx;
    end
  end
endmodule

// File: rtl/resp_seq.sv
module resp_seq
  import resp_pkg::*;
#(
  parameter int unsigned     DW         = 16,
  parameter int unsigned     ZW         = 4,
  parameter int unsigned     DELAY      = 3,
  parameter int unsigned     RATE       = 2,
  parameter logic [DW-1:0]   DUMMY_WORD = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rq_empty,
  input  logic [ZW-1:0] rq_size,
  output logic          rq_pop,
  input  logic          buf_empty,
  input  logic [DW-1:0] buf_head,
  output logic          buf_pop,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  output logic          out_real
);
  localparam int unsigned MAXT = max_of(DELAY, RATE);
  localparam int unsigned TW   = $clog2(MAXT + 1);

  sq_state_e     state, state_nx;
  logic [ZW-1:0] left, left_nx;
  logic [TW-1:0] tick, tick_nx;
  logic          fire;
  logic          valid_q, real_q;
  logic [DW-1:0] data_q, data_nx;

  always_comb begin
    state_nx = state;
    left_nx  = left;
    tick_nx  = tick;
    rq_pop   = 1'b0;
    buf_pop  = 1'b0;
    fire     = 1'b0;
    unique case (state)
      SQ_IDLE: begin
        if (!rq_empty) begin
          rq_pop   = 1'b1;
          left_nx  = rq_size;
          tick_nx  = TW'(DELAY - 1);
          state_nx = SQ_RUN;
        end
      end
      SQ_RUN: begin
        if (tick == '0) begin
          fire    = 1'b1;
          buf_pop = !buf_empty;
          left_nx = left - ZW'(1);
          tick_nx = TW'(RATE - 1);
          if (left == ZW'(1)) state_nx = SQ_IDLE;
        end else begin
          tick_nx = tick - TW'(1);
        end
      end
      default: state_nx = SQ_IDLE;
    endcase
  end

  assign data_nx = buf_empty ? DUMMY_WORD : buf_head;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= SQ_IDLE;
      left  <= '0;
      tick  <= '0;
    end else begin
      state <= state_nx;
      left  <= left_nx;
      tick  <= tick_nx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      real_q  <= 1'b0;
      data_q  <= '0;
    end else begin
      valid_q <= fire;
      real_q  <= fire && !buf_empty;
      if (fire) data_q <= data_nx;
    end
  end

  assign out_valid = valid_q;
  assign out_data  = data_q;
  assign out_real  = real_q;
endmodule

// File: rtl/fixed_pattern_responder.sv
module fixed_pattern_responder #(
  parameter int unsigned   DW         = 16,
  parameter int unsigned   DEPTH      = 4,
  parameter int unsigned   ZW         = 4,
  parameter int unsigned   DELAY      = 3,
  parameter int unsigned   RATE       = 2,
  parameter int unsigned   RQ_DEPTH   = 2,
  parameter logic [DW-1:0] DUMMY_WORD = 16'hD00D
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_valid,
  input  logic [DW-1:0]              wr_data,
  output logic                       wr_full,
  output logic [$clog2(DEPTH+1)-1:0] occupancy,
  output logic                       empty,
  input  logic                       req_valid,
  input  logic [ZW-1:0]              req_size,
  output logic                       out_valid,
  output logic [DW-1:0]              out_data,
  output logic                       out_real
);
  localparam int unsigned QCW = $clog2(RQ_DEPTH + 1);

  logic          buf_pop;
  logic [DW-1:0] buf_head;
  logic          rq_push, rq_pop, rq_full, rq_empty;
  logic [ZW-1:0] rq_size;
  logic [QCW-1:0] rq_level;

  assign rq_push = req_valid && (req_size != '0) && !rq_full;

  resp_sync_fifo #(.W(DW), .DEPTH(DEPTH)) u_buf (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (wr_valid),
    .din   (wr_data),
    .pop   (buf_pop),
    .dout  (buf_head),
    .full  (wr_full),
    .empty (empty),
    .count (occupancy)
  );

  resp_sync_fifo #(.W(ZW), .DEPTH(RQ_DEPTH)) u_rq (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (rq_push),
    .din   (req_size),
    .pop   (rq_pop),
    .dout  (rq_size),
    .full  (rq_full),
    .empty (rq_empty),
    .count (rq_level)
  );

  resp_seq #(
    .DW(DW), .ZW(ZW), .DELAY(DELAY), .RATE(RATE), .DUMMY_WORD(DUMMY_WORD)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .rq_empty  (rq_empty),
    .rq_size   (rq_size),
    .rq_pop    (rq_pop),
    .buf_empty (empty),
    .buf_head  (buf_head),
    .buf_pop   (buf_pop),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_real  (out_real)
  );
endmodule

// File: rtl/resp_checker.sv
module resp_checker #(
  parameter int unsigned DEPTH    = 4,
  parameter int unsigned RQ_DEPTH = 2,
  parameter int unsigned RATE     = 2
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          wr_full,
  input logic                          empty,
  input logic [$clog2(DEPTH+1)-1:0]    occupancy,
  input logic                          out_valid,
  input logic                          out_real,
  input logic [$clog2(RQ_DEPTH+1)-1:0] rq_level
);
  localparam int unsigned CW  = $clog2(DEPTH + 1);
  localparam int unsigned QCW = $clog2(RQ_DEPTH + 1);
  localparam bit          SPACED = (RATE > 1);

  // R7
  occ_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    occupancy <= CW'(DEPTH));

  // R6
  full_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_full |=> occupancy <= $past(occupancy));

  // R6
  full_empty_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_full && empty));

  // R5
  dummy_on_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_real) |-> $past(empty));

  // R4
  real_needs_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_real) |-> !$past(empty));

  // R3
  rate_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (SPACED && out_valid) |=> !out_valid);

  // R9
  rq_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rq_level <= QCW'(RQ_DEPTH));
endmodule

bind fixed_pattern_responder resp_checker #(
  .DEPTH(DEPTH), .RQ_DEPTH(RQ_DEPTH), .RATE(RATE)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_full   (wr_full),
  .empty     (empty),
  .occupancy (occupancy),
  .out_valid (out_valid),
  .out_real  (out_real),
  .rq_level  (rq_level)
);

// File: tb/tb_fixed_pattern_responder.sv
`timescale 1ns/1ps
module tb_fixed_pattern_responder;
  localparam int unsigned DW       = 16;
  localparam int unsigned DEPTH    = 4;
  localparam int unsigned ZW       = 4;
  localparam int          DELAY    = 3;
  localparam int          RATE     = 2;
  localparam int unsigned RQ_DEPTH = 2;
  localparam logic [DW-1:0] DUMMY  = 16'hD00D;
  localparam int unsigned CW       = $clog2(DEPTH + 1);

  logic          clk = 1'b0;
  logic          rst_n;
  logic          wr_valid;
  logic [DW-1:0] wr_data;
  logic          wr_full;
  logic [CW-1:0] occupancy;
  logic          empty;
  logic          req_valid;
  logic [ZW-1:0] req_size;
  logic          out_valid;
  logic [DW-1:0] out_data;
  logic          out_real;

  int n_pass = 0;
  int n_total = 0;
  int cyc = 0;
  int n_log = 0;
  int          log_cyc  [64];
  logic [DW-1:0] log_data [64];
  logic        log_real [64];

  always #2.5 clk = ~clk;

  fixed_pattern_responder #(
    .DW(DW), .DEPTH(DEPTH), .ZW(ZW), .DELAY(DELAY), .RATE(RATE),
    .RQ_DEPTH(RQ_DEPTH), .DUMMY_WORD(DUMMY)
  ) dut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
    .wr_full(wr_full), .occupancy(occupancy), .empty(empty),
    .req_valid(req_valid), .req_size(req_size),
    .out_valid(out_valid), .out_data(out_data), .out_real(out_real)
  );

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rst_n && out_valid && n_log < 64) begin
      log_cyc[n_log]  = cyc;
      log_data[n_log] = out_data;
      log_real[n_log] = out_real;
      n_log = n_log + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_total++;
    if (ok) n_pass++;
    else $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic push_word(input logic [DW-1:0] v);
    @(negedge clk);
    wr_valid = 1'b1;
    wr_data  = v;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic expect_word(input int i, input int at, input logic [DW-1:0] d,
                             input logic r, input string req);
    if (i >= n_log) begin
      chk(1'b0, req, "missing word", n_log, i + 1);
    end else begin
      chk(log_cyc[i] == at, "R3", "word edge", log_cyc[i], at);
      chk(log_data[i] == d, req, "word value", int'(log_data[i]), int'(d));
      chk(log_real[i] == r, req, "real tag", int'(log_real[i]), int'(r));
    end
  endtask

  // R1
  task automatic t_reset();
    chk(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);
    chk(empty == 1'b1, "R1", "empty after reset", empty, 1);
    chk(occupancy == 0, "R1", "occupancy after reset", occupancy, 0);
    chk(wr_full == 1'b0, "R1", "full after reset", wr_full, 0);
  endtask

  // R1, R7: data present but no request -> silence
  task automatic t_no_request();
    n_log = 0;
    push_word(16'hA001);
    push_word(16'hA002);
    idle(20);
    chk(n_log == 0, "R1", "words without request", n_log, 0);
    chk(occupancy == 2, "R7", "occupancy after two writes", occupancy, 2);
    chk(empty == 1'b0, "R7", "empty with data", empty, 0);
  endtask

  // R2 R3 R4 R5: two buffered words, request of three
  task automatic t_mixed();
    int c;
    n_log = 0;
    @(negedge clk);
    req_valid = 1'b1;
    req_size  = 3;
    c = cyc;
    @(negedge clk);
    req_valid = 1'b0;
    idle(DELAY + 3 * RATE + 10);
    chk(n_log == 3, "R2", "word count Z=3", n_log, 3);
    expect_word(0, c + 2 + DELAY,            16'hA001, 1'b1, "R4");
    expect_word(1, c + 2 + DELAY + RATE,     16'hA002, 1'b1, "R4");
    expect_word(2, c + 2 + DELAY + 2 * RATE, DUMMY,    1'b0, "R5");
    chk(occupancy == 0, "R7", "occupancy after drain", occupancy, 0);
    chk(empty == 1'b1, "R7", "empty after drain", empty, 1);
  endtask

  // R6: fill, blocked write, drain in order
  task automatic t_full();
    int c;
    for (int i = 0; i < DEPTH; i++) push_word(DW'(16'h1000 + i));
    chk(wr_full == 1'b1, "R6", "full at DEPTH", wr_full, 1);
    chk(occupancy == DEPTH, "R6", "occupancy at full", occupancy, DEPTH);
    push_word(16'hBEEF);
    chk(occupancy == DEPTH, "R6", "occupancy after blocked write", occupancy, DEPTH);
    n_log = 0;
    @(negedge clk);
    req_valid = 1'b1;
    req_size  = ZW'(DEPTH + 1);
    c = cyc;
    @(negedge clk);
    req_valid = 1'b0;
    chk(wr_full == 1'b1, "R6", "still full before first slot", wr_full, 1);
    idle(DELAY + (DEPTH + 1) * RATE + 10);
    chk(n_log == DEPTH + 1, "R2", "word count Z=DEPTH+1", n_log, DEPTH + 1);
    for (int i = 0; i < DEPTH; i++)
      expect_word(i, c + 2 + DELAY + i * RATE, DW'(16'h1000 + i), 1'b1, "R6");
    expect_word(DEPTH, c + 2 + DELAY + DEPTH * RATE, DUMMY, 1'b0, "R6");
    chk(wr_full == 1'b0, "R6", "full clears after drain", wr_full, 0);
  endtask

  // R8 R9: back-to-back requests, queue overflow, zero size
  task automatic t_queue();
    int c, a0, a1, b0, c0;
    n_log = 0;
    @(negedge clk);
    req_valid = 1'b1;
    req_size  = 2;
    c = cyc;
    @(negedge clk);
    req_size = 1;
    @(negedge clk);
    req_size = 1;
    @(negedge clk);
    req_size = 1;
    @(negedge clk);
    req_valid = 1'b0;
    idle(4 * DELAY + 4 * RATE + 20);
    a0 = c + 2 + DELAY;
    a1 = a0 + RATE;
    b0 = a1 + 1 + DELAY;
    c0 = b0 + 1 + DELAY;
    chk(n_log == 4, "R9", "words with dropped request", n_log, 4);
    expect_word(0, a0, DUMMY, 1'b0, "R5");
    expect_word(1, a1, DUMMY, 1'b0, "R5");
    expect_word(2, b0, DUMMY, 1'b0, "R8");
    expect_word(3, c0, DUMMY, 1'b0, "R8");
    n_log = 0;
    @(negedge clk);
    req_valid = 1'b1;
    req_size  = 0;
    @(negedge clk);
    req_valid = 1'b0;
    idle(DELAY + RATE + 10);
    chk(n_log == 0, "R9", "words for zero-size request", n_log, 0);
  endtask

  initial begin
    rst_n     = 1'b0;
    wr_valid  = 1'b0;
    wr_data   = '0;
    req_valid = 1'b0;
    req_size  = '0;
    idle(3);
    rst_n = 1'b1;
    idle(1);
    t_reset();
    t_no_request();
    t_mixed();
    t_full();
    t_queue();
    $display("%0d/%0d checks passed", n_pass, n_total);
    $finish;
  end

  initial begin
    for (int i = 0; i < 20000; i++) @(posedge clk);
    chk(1'b0, "R1", "watchdog expired", cyc, 0);
    $display("%0d/%0d checks passed", n_pass, n_total);
    $finish;
  end
endmodule